// File: doc/BRIEF.md
# Multi-Bus Byte Datapath Slice

This block is the register-transfer core of a classic 8-bit accumulator processor. It has no sequencer of its own. It only moves bytes between registers over four internal byte buses. These are a special bus, an address-low bus, an address-high bus and a data bus. An external microstep controller raises one control word per clock, and that word names every bus source and every register load for the cycle.

A bus that nothing drives reads as all ones, which models a precharged line. Forced-zero pulldowns can then clear chosen bits of either address bus, so address constants such as page one or 0xFE need no storage. The ALU takes its two operands from latches that load only on command. Its result is captured into a result latch on every clock, so an operation and its writeback fall into consecutive cycles. Index registers reach the ALU only through the special bus. The 16-bit address output comes from an address register loaded from the two address buses.

Top module: `mbdp_slice`

## Requirements
- R1: A synchronous active-high reset clears the following state to zero:
  - A, X, Y and S;
  - the program counter and the address register;
  - both ALU operand latches and the ALU result latch.
- R2: Each of the four buses carries the bitwise AND of the sources enabled onto it, and reads 0xFF when no source is enabled. The controller enables at most one source per bus per cycle. The control word is the packed struct `ctl_t` of `mbdp_pkg`, cast from the `ctl` port. The data bus sources are `din` and A.
- R3: Pulldowns clear address-bus bits after the drivers are resolved:
  - `adl_pd0` clears bit 0 of the address-low bus;
  - `adl_pd1` clears bit 1 of the address-low bus;
  - `adl_pd72` clears bits 7..2 of the address-low bus;
  - `adh_pd0` clears bit 0 of the address-high bus;
  - `adh_pd71` clears bits 7..1 of the address-high bus.
- R4: X and Y load only from the special bus (`sb_x`, `sb_y`) and drive only the special bus. Without their load strobe they hold.
- R5: A loads the special-bus value when `sb_a` is set and otherwise holds. A can drive the special bus or the data bus.
- R6: The operand latches load only on command, and a value loaded in a cycle is already used by the ALU in that cycle. Without a load strobe each latch holds its value.
  - Operand A loads from the special bus on `sb_alua`.
  - Operand B loads from the data bus (`db_alub`), from the address-low bus (`adl_alub`) or with zero (`zero_alub`).
- R7: The result latch captures the ALU output on every clock. `op` encodes ADD=0 (a+b+cin, modulo 256), PASS=1 (a), AND=2 and XOR=3. The latched result can drive the special bus (`alu_sb`).
- R8: Each half of the program counter takes either its address bus (`adl_pcl`, `adh_pch`) or its own value. The 16-bit result is then incremented when `pc_inc` is set and registered. The PC low and high halves can drive the address-low and address-high buses.
- R9: The address output low byte loads the address-low bus on `adl_abl`, and the high byte loads the address-high bus on `adh_abh`. Otherwise each byte holds.
- R10: S loads from the special bus (`sb_s`) and can drive the special bus or the address-low bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 34 | Per-cycle control word (`ctl_t`) |
| din | input | 8 | External data-in byte |
| addr | output | 16 | Address register {high, low} |
| a_out | output | 8 | Accumulator |
| x_out | output | 8 | Index X |
| y_out | output | 8 | Index Y |
| s_out | output | 8 | Stack pointer |
| pc_out | output | 16 | Program counter |
| alu_out | output | 8 | ALU result latch |

## Verification
The bench replays the two-cycle increment of X, including the wrap from 0xFF to 0x00. A design that wrote the ALU result back in the same cycle, or that fed stale operands, would leave X off by one or a cycle late. It builds the stack push address {0x01, S} from the pulldowns and the precharged address-high bus. It also drives address bytes with nothing enabled, which would expose a bus that floats to zero rather than 0xFF. Holding the operand latches across several operations shows whether they wrongly reload every clock. A same-cycle PC load and increment that wraps 0xFFFF to 0x0000 catches an incrementer applied before the bus selection.

// File: rtl/mbdp_pkg.sv
package mbdp_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'd0,
        ALU_PASS = 2'd1,
        ALU_AND  = 2'd2,
        ALU_XOR  = 2'd3
    } alu_op_e;

    // One control word per microstep
    typedef struct packed {
        // special-bus sources
        logic    a_sb;
        logic    x_sb;
        logic    y_sb;
        logic    s_sb;
        logic    alu_sb;
        logic    db_sb;
        // address-low sources
        logic    pcl_adl;
        logic    s_adl;
        logic    db_adl;
        // address-high sources
        logic    pch_adh;
        logic    db_adh;
        // data-bus sources
        logic    din_db;
        logic    a_db;
        // forced-zero pulldowns
        logic    adl_pd0;
        logic    adl_pd1;
        logic    adl_pd72;
        logic    adh_pd0;
        logic    adh_pd71;
        // register loads
        logic    sb_a;
        logic    sb_x;
        logic    sb_y;
        logic    sb_s;
        logic    sb_alua;
        logic    db_alub;
        logic    adl_alub;
        logic    zero_alub;
        // program counter
        logic    adl_pcl;
        logic    adh_pch;
        logic    pc_inc;
        // address register
        logic    adl_abl;
        logic    adh_abh;
        // ALU
        alu_op_e op;
        logic    cin;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [DW-1:0] alu_eval(input alu_op_e op,
                                               input logic [DW-1:0] a,
                                               input logic [DW-1:0] b,
                                               input logic cin);
        logic [DW-1:0] r;
        unique case (op)
            ALU_ADD:  r = a + b + {{(DW-1){1'b0}}, cin};
            ALU_PASS: r = a;
            ALU_AND:  r = a & b;
            default:  r = a ^ b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mbdp_bus.sv
module mbdp_bus #(
    parameter int W = mbdp_pkg::DW,
    parameter int N = 2
) (
    input  logic [N-1:0]        en,
    input  logic [N-1:0][W-1:0] src,
    input  logic [W-1:0]        pull,
    output logic [W-1:0]        val
);
    // precharged line: every enabled source can only pull bits low
    logic [N:0][W-1:0] chain;

    assign chain[0] = '1;

    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            assign chain[i+1] = chain[i] & (en[i] ? src[i] : {W{1'b1}});
        end
    endgenerate

    assign val = chain[N] & ~pull;

endmodule

// File: rtl/mbdp_alu.sv
module mbdp_alu #(
    parameter int W = mbdp_pkg::DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     sb,
    input  logic [W-1:0]     db,
    input  logic [W-1:0]     adl,
    input  logic             ld_a,
    input  logic             ld_b_db,
    input  logic             ld_b_adl,
    input  logic             ld_b_zero,
    input  mbdp_pkg::alu_op_e op,
    input  logic             cin,
    output logic [W-1:0]     res
);
    logic [W-1:0] opa_q, opb_q, opa_eff, opb_eff, res_q;

    // a loaded operand is seen by the ALU within the same cycle
    always_comb begin
        opa_eff = ld_a ? sb : opa_q;
        if (ld_b_zero)     opb_eff = '0;
        else if (ld_b_db)  opb_eff = db;
        else if (ld_b_adl) opb_eff = adl;
        else               opb_eff = opb_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q <= '0;
            opb_q <= '0;
            res_q <= '0;
        end else begin
            opa_q <= opa_eff;
            opb_q <= opb_eff;
            res_q <= mbdp_pkg::alu_eval(op, opa_eff, opb_eff, cin);
        end
    end

    assign res = res_q;

endmodule

// File: rtl/mbdp_pc.sv
module mbdp_pc #(
    parameter int             W        = mbdp_pkg::DW,
    parameter logic [2*W-1:0] RESET_PC = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   adl,
    input  logic [W-1:0]   adh,
    input  logic           ld_lo,
    input  logic           ld_hi,
    input  logic           inc,
    output logic [2*W-1:0] pc
);
    localparam int PW = 2 * W;

    logic [PW-1:0] pc_q, sel;

    assign sel = {ld_hi ? adh : pc_q[PW-1:W], ld_lo ? adl : pc_q[W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= sel + {{(PW-1){1'b0}}, inc};
    end

    assign pc = pc_q;

endmodule

// File: rtl/mbdp_slice.sv
module mbdp_slice
    import mbdp_pkg::*;
#(
    parameter int W = DW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CTL_W-1:0]   ctl,
    input  logic [W-1:0]       din,
    output logic [2*W-1:0]     addr,
    output logic [W-1:0]       a_out,
    output logic [W-1:0]       x_out,
    output logic [W-1:0]       y_out,
    output logic [W-1:0]       s_out,
    output logic [2*W-1:0]     pc_out,
    output logic [W-1:0]       alu_out
);
    localparam int NREG = 4;
    localparam int RA = 0;
    localparam int RX = 1;
    localparam int RY = 2;
    localparam int RS = 3;

    ctl_t c;
    assign c = ctl_t'(ctl);

    logic [NREG-1:0][W-1:0] reg_q;
    logic [NREG-1:0]        reg_ld;
    logic [W-1:0]           sb, db, adl, adh, alu_q;
    logic [2*W-1:0]         pc_q;
    logic [W-1:0]           abl_q, abh_q;

    // data bus
    mbdp_bus #(.W(W), .N(2)) u_db (
        .en   ({c.a_db, c.din_db}),
        .src  ({reg_q[RA], din}),
        .pull ('0),
        .val  (db)
    );

    // special bus: the only path into and out of X and Y
    mbdp_bus #(.W(W), .N(6)) u_sb (
        .en   ({c.db_sb, c.alu_sb, c.s_sb, c.y_sb, c.x_sb, c.a_sb}),
        .src  ({db, alu_q, reg_q[RS], reg_q[RY], reg_q[RX], reg_q[RA]}),
        .pull ('0),
        .val  (sb)
    );

    // address-low bus with small-constant pulldowns
    mbdp_bus #(.W(W), .N(3)) u_adl (
        .en   ({c.db_adl, c.s_adl, c.pcl_adl}),
        .src  ({db, reg_q[RS], pc_q[W-1:0]}),
        .pull ({{(W-2){c.adl_pd72}}, c.adl_pd1, c.adl_pd0}),
        .val  (adl)
    );

    // address-high bus with page pulldowns
    mbdp_bus #(.W(W), .N(2)) u_adh (
        .en   ({c.db_adh, c.pch_adh}),
        .src  ({db, pc_q[2*W-1:W]}),
        .pull ({{(W-1){c.adh_pd71}}, c.adh_pd0}),
        .val  (adh)
    );

    mbdp_alu #(.W(W)) u_alu (
        .clk       (clk),
        .rst       (rst),
        .sb        (sb),
        .db        (db),
        .adl       (adl),
        .ld_a      (c.sb_alua),
        .ld_b_db   (c.db_alub),
        .ld_b_adl  (c.adl_alub),
        .ld_b_zero (c.zero_alub),
        .op        (c.op),
        .cin       (c.cin),
        .res       (alu_q)
    );

    mbdp_pc #(.W(W)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .adl   (adl),
        .adh   (adh),
        .ld_lo (c.adl_pcl),
        .ld_hi (c.adh_pch),
        .inc   (c.pc_inc),
        .pc    (pc_q)
    );

    // register file: every register loads only from the special bus
    assign reg_ld = {c.sb_s, c.sb_y, c.sb_x, c.sb_a};

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)            reg_q[r] <= '0;
                else if (reg_ld[r]) reg_q[r] <= sb;
            end
        end
    endgenerate

    // address register
    always_ff @(posedge clk) begin
        if (rst) begin
            abl_q <= '0;
            abh_q <= '0;
        end else begin
            if (c.adl_abl) abl_q <= adl;
            if (c.adh_abh) abh_q <= adh;
        end
    end

    assign addr    = {abh_q, abl_q};
    assign a_out   = reg_q[RA];
    assign x_out   = reg_q[RX];
    assign y_out   = reg_q[RY];
    assign s_out   = reg_q[RS];
    assign pc_out  = pc_q;
    assign alu_out = alu_q;

endmodule

// File: rtl/mbdp_slice_chk.sv
module mbdp_slice_chk
    import mbdp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CTL_W-1:0] ctl,
    input logic [AW-1:0]    addr,
    input logic [DW-1:0]    a,
    input logic [DW-1:0]    x,
    input logic [DW-1:0]    y,
    input logic [AW-1:0]    pc
);
    ctl_t c;
    assign c = ctl_t'(ctl);

    // R2
    sb_one_drv_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({c.a_sb, c.x_sb, c.y_sb, c.s_sb, c.alu_sb, c.db_sb}) <= 1);

    // R2
    adl_one_drv_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({c.pcl_adl, c.s_adl, c.db_adl}) <= 1);

    // R2
    adh_one_drv_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({c.pch_adh, c.db_adh}) <= 1);

    // R4
    x_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !c.sb_x |=> $stable(x));

    // R4
    y_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !c.sb_y |=> $stable(y));

    // R5
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !c.sb_a |=> $stable(a));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (c.pc_inc && !c.adl_pcl && !c.adh_pch) |=> pc == $past(pc) + 16'd1);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!c.adl_abl && !c.adh_abh) |=> $stable(addr));

    // R3
    stack_page_chk: assert property (@(posedge clk) disable iff (rst)
        (c.adh_abh && c.adh_pd71 && !c.adh_pd0 && !c.pch_adh && !c.db_adh)
        |=> addr[AW-1:DW] == DW'(1));

endmodule

bind mbdp_slice mbdp_slice_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl),
    .addr (addr),
    .a    (a_out),
    .x    (x_out),
    .y    (y_out),
    .pc   (pc_out)
);

// File: tb/mbdp_slice_test.sv
module mbdp_slice_test;
    import mbdp_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    ctl_t             c   = '0;
    logic [DW-1:0]    din = '0;
    logic [AW-1:0]    addr, pc_out;
    logic [DW-1:0]    a_out, x_out, y_out, s_out, alu_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mbdp_slice uut (
        .clk     (clk),
        .rst     (rst),
        .ctl     (c),
        .din     (din),
        .addr    (addr),
        .a_out   (a_out),
        .x_out   (x_out),
        .y_out   (y_out),
        .s_out   (s_out),
        .pc_out  (pc_out),
        .alu_out (alu_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // apply one control word for one clock, then settle past the edge
    task automatic cyc(input ctl_t w);
        c = w;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        c   = '0;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        chk("R1", "a",    a_out,   16'h0);
        chk("R1", "x",    x_out,   16'h0);
        chk("R1", "y",    y_out,   16'h0);
        chk("R1", "s",    s_out,   16'h0);
        chk("R1", "pc",   pc_out,  16'h0);
        chk("R1", "addr", addr,    16'h0);
        chk("R1", "alu",  alu_out, 16'h0);
    endtask

    task automatic t_precharge;
        ctl_t w;
        w = '0; w.adl_abl = 1; w.adh_abh = 1;
        cyc(w);
        chk("R2", "undriven buses", addr, 16'hFFFF);
        chk("R8", "pc idle", pc_out, 16'h0000);
        w = '0; w.adl_abl = 1; w.adh_abh = 1;
        w.adl_pd1 = 1; w.adl_pd72 = 1; w.adh_pd0 = 1; w.adh_pd71 = 1;
        cyc(w);
        chk("R3", "const 0x0001", addr, 16'h0001);
        w = '0; w.adl_abl = 1; w.adh_abh = 1; w.adl_pd0 = 1; w.adh_pd71 = 1;
        cyc(w);
        chk("R3", "const 0x01FE", addr, 16'h01FE);
        w = '0; w.adl_abl = 1; w.adh_abh = 1;
        w.adl_pd0 = 1; w.adl_pd1 = 1; w.adl_pd72 = 1;
        cyc(w);
        chk("R3", "const 0xFF00", addr, 16'hFF00);
        cyc('0);
        chk("R9", "addr hold", addr, 16'hFF00);
    endtask

    task automatic t_acc_and_index;
        ctl_t w;
        din = 8'h5A;
        w = '0; w.din_db = 1; w.db_sb = 1; w.sb_a = 1;
        cyc(w);
        chk("R5", "a from din", a_out, 16'h005A);
        chk("R4", "x untouched", x_out, 16'h0000);
        din = 8'h33;
        w = '0; w.din_db = 1; w.db_adl = 1; w.adl_abl = 1;
        cyc(w);
        chk("R5", "a hold", a_out, 16'h005A);
        chk("R4", "x not on db/adl", x_out, 16'h0000);
        chk("R9", "abl only", addr, 16'hFF33);
        w = '0; w.a_sb = 1; w.sb_x = 1;
        cyc(w);
        chk("R4", "x from sb", x_out, 16'h005A);
        chk("R4", "y hold", y_out, 16'h0000);
        w = '0; w.a_sb = 1; w.sb_y = 1;
        cyc(w);
        chk("R4", "y from sb", y_out, 16'h005A);
    endtask

    task automatic inx_pair(input logic [7:0] x_exp, input logic [15:0] pc0,
                            input logic [7:0] sum, input logic [7:0] pass);
        ctl_t w;
        w = '0; w.x_sb = 1; w.sb_alua = 1; w.zero_alub = 1;
        w.op = ALU_ADD; w.cin = 1;
        w.pcl_adl = 1; w.pch_adh = 1; w.adl_abl = 1; w.adh_abh = 1;
        w.adl_pcl = 1; w.adh_pch = 1;
        cyc(w);
        chk("R9", "inx c1 addr", addr, pc0);
        chk("R8", "inx c1 pc", pc_out, pc0);
        chk("R6", "inx c1 alu", alu_out, {8'h0, sum});
        w = '0; w.alu_sb = 1; w.sb_x = 1; w.pc_inc = 1; w.op = ALU_PASS;
        cyc(w);
        chk("R4", "inx c2 x", x_out, {8'h0, x_exp});
        chk("R8", "inx c2 pc", pc_out, pc0 + 16'd1);
        chk("R9", "inx c2 addr", addr, pc0);
        chk("R7", "inx c2 latch", alu_out, {8'h0, pass});
    endtask

    task automatic t_inx;
        ctl_t w;
        din = 8'h12;
        w = '0; w.din_db = 1; w.db_adl = 1; w.db_adh = 1;
        w.adl_pcl = 1; w.adh_pch = 1;
        cyc(w);
        chk("R8", "pc load", pc_out, 16'h1212);
        inx_pair(8'h5B, 16'h1212, 8'h5B, 8'h5A);
        din = 8'hFF;
        w = '0; w.din_db = 1; w.db_sb = 1; w.sb_x = 1;
        cyc(w);
        chk("R4", "x=ff", x_out, 16'h00FF);
        chk("R7", "held operands add", alu_out, 16'h005A);
        inx_pair(8'h00, 16'h1213, 8'h00, 8'hFF);
    endtask

    task automatic t_push;
        ctl_t w;
        din = 8'hFD;
        w = '0; w.din_db = 1; w.db_sb = 1; w.sb_s = 1;
        cyc(w);
        chk("R10", "s load", s_out, 16'h00FD);
        w = '0; w.s_adl = 1; w.adh_pd71 = 1; w.adl_abl = 1; w.adh_abh = 1;
        cyc(w);
        chk("R3", "push addr", addr, 16'h01FD);
        chk("R10", "s hold", s_out, 16'h00FD);
    endtask

    task automatic t_alu;
        ctl_t w;
        din = 8'h0F;
        w = '0; w.a_sb = 1; w.sb_alua = 1; w.din_db = 1; w.db_alub = 1;
        w.op = ALU_AND;
        cyc(w);
        chk("R7", "and", alu_out, 16'h000A);
        w = '0; w.op = ALU_XOR;
        cyc(w);
        chk("R6", "xor held", alu_out, 16'h0055);
        w = '0; w.op = ALU_ADD;
        cyc(w);
        chk("R6", "add held", alu_out, 16'h0069);
        w = '0; w.s_adl = 1; w.adl_alub = 1; w.op = ALU_ADD; w.cin = 1;
        cyc(w);
        chk("R6", "b from adl", alu_out, 16'h0058);
        w = '0; w.alu_sb = 1; w.sb_a = 1; w.op = ALU_PASS;
        cyc(w);
        chk("R5", "a from alu", a_out, 16'h0058);
        chk("R7", "pass", alu_out, 16'h005A);
    endtask

    task automatic t_misc;
        ctl_t w;
        din = 8'hFF;
        w = '0; w.din_db = 1; w.db_adl = 1; w.db_adh = 1;
        w.adl_pcl = 1; w.adh_pch = 1; w.pc_inc = 1;
        cyc(w);
        chk("R8", "load+inc wrap", pc_out, 16'h0000);
        w = '0; w.s_sb = 1; w.sb_y = 1;
        cyc(w);
        chk("R10", "s to y", y_out, 16'h00FD);
        w = '0; w.a_db = 1; w.db_sb = 1; w.sb_x = 1;
        cyc(w);
        chk("R5", "a via db", x_out, 16'h0058);
    endtask

    initial begin
        t_reset();
        t_precharge();
        t_acc_and_index();
        t_inx();
        t_push();
        t_alu();
        t_misc();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule